// File: doc/BRIEF.md
# Signed-Zero Ternary Weight Encoder

This block quantizes a stream of signed fixed-point latent weights into 2-bit codes. Each weight is compared against a strictly positive, symmetric threshold. The result falls into one of four classes: a strong positive, a strong negative, or a zero that keeps the sign of the weight. Keeping the sign of sub-threshold weights preserves one extra bit of information for training. A downstream multiply stage still sees only three numeric levels, because both zero classes decode to 0.

Each weight arrives with a channel index. The index selects one threshold from a small bank, and that bank can be reloaded between layers or groups. Accepted weights leave one cycle later on a symbol stream, which carries the 2-bit code and its 2-bit two's-complement level. In the same handshake, the code is appended to a packing word. The packing word is released when it is full, or on a flush request if it is only partly filled. All three streams (weights in, symbols out, words out) use valid/ready handshakes.

Top module: `szt_encoder`

## Requirements
- R1: A weight strictly greater than its threshold T encodes as code 2'b01 (strong positive).
- R2: A weight w with 0 <= w <= T encodes as code 2'b00 (positive zero); an exact zero takes this code.
- R3: A weight w with -T <= w < 0 encodes as code 2'b10 (negative zero); bit 1 of every code is the sign.
- R4: A weight strictly below -T encodes as code 2'b11 (strong negative).
- R5: Each of NUM_CH channels holds its own threshold, reset to THR_RESET. A load writes the threshold of the addressed channel, but a load value that is zero or negative leaves it unchanged. A weight accepted in the same cycle as a load still uses the old threshold.
- R6: sym_value is the numeric level in 2-bit two's complement: 2'b01 for code 2'b01, 2'b11 for code 2'b11, and 2'b00 for either zero code. sym_valid rises on the cycle after a weight is accepted.
- R7: The first code of a word goes in bits [1:0], and code k goes in bits [2k+1:2k]. After CODES_PER_WORD codes, word_valid rises with word_fill = CODES_PER_WORD.
- R8: An accepted flush emits a partial word: word_fill equals the number of codes held, and all unused high bits are zero. A flush with no codes held emits nothing. word_fill is never 0 while word_valid is high.
- R9: Under back-pressure no code is lost or duplicated. Any output that is valid but not ready holds its value until it is taken.
- R10: During reset sym_valid and word_valid are low, and in_ready and flush_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_load | input | 1 | Threshold write strobe |
| thr_chan | input | $clog2(NUM_CH) | Channel written by the load |
| thr_value | input | W | Signed threshold value; applied only if positive |
| in_valid | input | 1 | Weight valid |
| in_ready | output | 1 | Weight accepted when high with in_valid |
| in_chan | input | $clog2(NUM_CH) | Threshold channel of this weight |
| in_weight | input | W | Signed latent weight |
| flush_valid | input | 1 | Request to release a partial word |
| flush_ready | output | 1 | Flush accepted when high with flush_valid |
| sym_valid | output | 1 | Symbol output valid |
| sym_ready | input | 1 | Symbol consumer ready |
| sym_code | output | 2 | Signed-zero code of the weight |
| sym_value | output | 2 | Decoded level, two's complement |
| word_valid | output | 1 | Packed word valid |
| word_ready | input | 1 | Word consumer ready |
| word_data | output | 2*CODES_PER_WORD | Packed codes, first code in the low bits |
| word_fill | output | $clog2(CODES_PER_WORD+1) | Number of codes in the word |

## Verification
The bench builds the encoder with an 8-bit weight width, four channels and sixteen codes per word. The narrow width lets random weights reach both ends of the signed range. It also allows thresholds up to full scale, so the cases T = 127 and a weight of -128 (which lies below -T) are covered. Four channels let the threshold change from one weight to the next. Random loads, some with non-positive values, can land in the same cycle as a weight. With sixteen codes per word, full words and partial flushes both occur many times under random back-pressure on both output streams.

// File: rtl/szt_pkg.sv
package szt_pkg;

  // Bit 1 carries the sign, bit 0 flags a magnitude of one.
  typedef enum logic [1:0] {
    SZT_ZERO_POS = 2'b00,
    SZT_ONE_POS  = 2'b01,
    SZT_ZERO_NEG = 2'b10,
    SZT_ONE_NEG  = 2'b11
  } szt_code_e;

  // Numeric level of a code as 2-bit two's complement.
  function automatic logic [1:0] szt_level(input logic [1:0] code);
    return {code[1] & code[0], code[0]};
  endfunction

endpackage

// File: rtl/szt_thr_bank.sv
module szt_thr_bank #(
  parameter int W         = 16,
  parameter int NUM_CH    = 4,
  parameter int THR_RESET = 1,
  localparam int CW       = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld,
  input  logic [CW-1:0]       ld_chan,
  input  logic signed [W-1:0] ld_value,
  input  logic [CW-1:0]       rd_chan,
  output logic signed [W-1:0] rd_thr
);

  logic ld_ok;
  logic signed [W-1:0] thr_q [NUM_CH];

  // Only strictly positive thresholds are meaningful.
  assign ld_ok = ld && (ld_value > 0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        thr_q[c] <= W'(THR_RESET);
      end else if (ld_ok && (ld_chan == CW'(c))) begin
        thr_q[c] <= ld_value;
      end
    end
  end

  assign rd_thr = thr_q[rd_chan];

endmodule

// File: rtl/szt_classify.sv
module szt_classify #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] weight,
  input  logic signed [W-1:0] thr,
  input  logic                take,
  output logic                st_valid,
  output logic [1:0]          st_code,
  output logic [1:0]          st_level
);
  import szt_pkg::*;

  szt_code_e           code_c;
  logic signed [W-1:0] neg_thr;

  assign neg_thr = -thr;

  always_comb begin
    if (weight > thr)          code_c = SZT_ONE_POS;
    else if (weight >= 0)      code_c = SZT_ZERO_POS;
    else if (weight >= neg_thr) code_c = SZT_ZERO_NEG;
    else                       code_c = SZT_ONE_NEG;
  end

  assign in_ready = !st_valid || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_code  <= 2'b00;
      st_level <= 2'b00;
    end else if (in_ready) begin
      st_valid <= in_valid;
      if (in_valid) begin
        st_code  <= code_c;
        st_level <= szt_level(code_c);
      end
    end
  end

endmodule

// File: rtl/szt_packer.sv
module szt_packer #(
  parameter int CPW = 16,
  localparam int WB = 2 * CPW,
  localparam int FW = $clog2(CPW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [1:0]    push_code,
  input  logic          flush,
  output logic          room,
  output logic          word_valid,
  input  logic          word_ready,
  output logic [WB-1:0] word_data,
  output logic [FW-1:0] word_fill
);

  logic [WB-1:0] acc_q, acc_n, shifted;
  logic [FW-1:0] cnt_q, cnt_n;
  logic          emit;

  assign room    = !word_valid || word_ready;
  assign shifted = WB'(push_code) << (2 * cnt_q);
  assign acc_n   = push ? (acc_q | shifted) : acc_q;
  assign cnt_n   = cnt_q + FW'(push);
  assign emit    = (cnt_n == FW'(CPW)) || (flush && (cnt_n != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_fill  <= '0;
    end else if (emit) begin
      word_data  <= acc_n;
      word_fill  <= cnt_n;
      word_valid <= 1'b1;
      acc_q      <= '0;
      cnt_q      <= '0;
    end else begin
      acc_q <= acc_n;
      cnt_q <= cnt_n;
      if (word_ready) word_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/szt_encoder.sv
module szt_encoder #(
  parameter int W              = 16,
  parameter int NUM_CH         = 4,
  parameter int CODES_PER_WORD = 16,
  parameter int THR_RESET      = 1,
  localparam int CW            = $clog2(NUM_CH),
  localparam int WB            = 2 * CODES_PER_WORD,
  localparam int FW            = $clog2(CODES_PER_WORD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          thr_load,
  input  logic [CW-1:0] thr_chan,
  input  logic [W-1:0]  thr_value,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_chan,
  input  logic [W-1:0]  in_weight,
  input  logic          flush_valid,
  output logic          flush_ready,
  output logic          sym_valid,
  input  logic          sym_ready,
  output logic [1:0]    sym_code,
  output logic [1:0]    sym_value,
  output logic          word_valid,
  input  logic          word_ready,
  output logic [WB-1:0] word_data,
  output logic [FW-1:0] word_fill
);

  logic signed [W-1:0] cur_thr;
  logic                st_valid, room, take, push, flush_fire;

  szt_thr_bank #(.W(W), .NUM_CH(NUM_CH), .THR_RESET(THR_RESET)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .ld       (thr_load),
    .ld_chan  (thr_chan),
    .ld_value (thr_value),
    .rd_chan  (in_chan),
    .rd_thr   (cur_thr)
  );

  szt_classify #(.W(W)) u_cls (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .weight   (in_weight),
    .thr      (cur_thr),
    .take     (take),
    .st_valid (st_valid),
    .st_code  (sym_code),
    .st_level (sym_value)
  );

  // A symbol leaves only when the packer can also take its code.
  assign take        = sym_ready && room;
  assign push        = st_valid && take;
  assign sym_valid   = st_valid && room;
  assign flush_ready = room && !st_valid;
  assign flush_fire  = flush_valid && flush_ready;

  szt_packer #(.CPW(CODES_PER_WORD)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_code  (sym_code),
    .flush      (flush_fire),
    .room       (room),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data),
    .word_fill  (word_fill)
  );

endmodule

// File: rtl/szt_encoder_chk.sv
module szt_encoder_chk #(
  parameter int W              = 16,
  parameter int CODES_PER_WORD = 16,
  localparam int WB            = 2 * CODES_PER_WORD,
  localparam int FW            = $clog2(CODES_PER_WORD + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_weight,
  input logic          sym_valid,
  input logic          sym_ready,
  input logic [1:0]    sym_code,
  input logic [1:0]    sym_value,
  input logic          word_valid,
  input logic          word_ready,
  input logic [WB-1:0] word_data,
  input logic [FW-1:0] word_fill
);

  AST_POS_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_weight[W-1]) |=> !sym_code[1]); // R1
  AST_ZERO_IS_POS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_weight == '0) |=> sym_code == 2'b00); // R2
  AST_NEG_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_weight[W-1]) |=> sym_code[1]); // R3
  AST_SYM_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (sym_valid || !word_ready || word_valid)); // R6
  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word_fill != '0 && word_fill <= FW'(CODES_PER_WORD))); // R8
  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_code) && $stable(sym_value))); // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && $stable(word_fill))); // R9

endmodule

bind szt_encoder szt_encoder_chk #(.W(W), .CODES_PER_WORD(CODES_PER_WORD)) u_chk (.*);

// File: tb/szt_encoder_bench.sv
module szt_encoder_bench;
  localparam int W = 8, NUM_CH = 4, CPW = 16, THR_RESET = 1;
  localparam int CW = $clog2(NUM_CH), WB = 2 * CPW, FW = $clog2(CPW + 1);

  logic clk = 0, rst = 1;
  logic thr_load = 0, in_valid = 0, flush_valid = 0, sym_ready = 0, word_ready = 0;
  logic [CW-1:0] thr_chan = '0, in_chan = '0;
  logic [W-1:0] thr_value = '0, in_weight = '0;
  logic in_ready, flush_ready, sym_valid, word_valid;
  logic [1:0] sym_code, sym_value;
  logic [WB-1:0] word_data;
  logic [FW-1:0] word_fill;

  always #10 clk = ~clk;

  szt_encoder #(.W(W), .NUM_CH(NUM_CH), .CODES_PER_WORD(CPW), .THR_RESET(THR_RESET)) u_szt_encoder (.*);

  typedef struct { int ch; int w; } item_t;
  item_t drv_q[$];
  logic [1:0] exp_sym[$];
  logic [WB-1:0] exp_wd[$];
  int exp_wf[$];
  int mthr[NUM_CH];
  logic [WB-1:0] macc;
  int mcnt, checks, bad;
  bit rnd_mode, flush_req, ld_pend, sym_hold, word_hold, done;
  int ld_ch, ld_val;
  logic [1:0] prev_code;
  logic [WB-1:0] prev_wd;

  function automatic logic [1:0] exp_code(int w, int t);
    if (w > t) return 2'b01;
    if (w >= 0) return 2'b00;
    if (w >= -t) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [1:0] exp_level(logic [1:0] c);
    if (c == 2'b01) return 2'b01;
    if (c == 2'b11) return 2'b11;
    return 2'b00;
  endfunction

  function automatic string tag_of(logic [1:0] c);
    case (c)
      2'b01: return "R1";
      2'b00: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    if (sym_hold) check(sym_valid && sym_code == prev_code, "R9", "stalled symbol held", {62'd0, sym_code}, {62'd0, prev_code});
    if (word_hold) check(word_valid && word_data == prev_wd, "R9", "stalled word held", 64'(word_data), 64'(prev_wd));
    in_valid = (drv_q.size() > 0) && (!rnd_mode || $urandom_range(0, 9) < 7);
    if (drv_q.size() > 0) begin
      in_chan = CW'(drv_q[0].ch);
      in_weight = W'(drv_q[0].w);
    end
    sym_ready = rnd_mode ? ($urandom_range(0, 9) < 8) : 1'b1;
    word_ready = rnd_mode ? ($urandom_range(0, 9) < 6) : 1'b1;
    flush_valid = flush_req;
    thr_load = ld_pend;
    thr_chan = CW'(ld_ch);
    thr_value = W'(ld_val);
    ld_pend = 0;
    #1;
    if (in_valid && in_ready) begin
      exp_sym.push_back(exp_code(int'($signed(in_weight)), mthr[in_chan]));
      void'(drv_q.pop_front());
    end
    if (thr_load && $signed(thr_value) > 0) mthr[thr_chan] = int'($signed(thr_value));
    if (sym_valid && sym_ready) begin
      if (exp_sym.size() == 0) begin
        check(0, "R9", "unexpected symbol", {62'd0, sym_code}, 64'd0);
      end else begin
        logic [1:0] c;
        c = exp_sym.pop_front();
        check(sym_code == c, tag_of(c), "code", {62'd0, sym_code}, {62'd0, c});
        check(sym_value == exp_level(c), "R6", "decoded level", {62'd0, sym_value}, {62'd0, exp_level(c)});
        macc = macc | (WB'(c) << (2 * mcnt));
        mcnt++;
        if (mcnt == CPW) begin
          exp_wd.push_back(macc); exp_wf.push_back(CPW);
          macc = '0; mcnt = 0;
        end
      end
    end
    if (flush_valid && flush_ready) begin
      flush_req = 0;
      if (mcnt > 0) begin
        exp_wd.push_back(macc); exp_wf.push_back(mcnt);
        macc = '0; mcnt = 0;
      end
    end
    if (word_valid && word_ready) begin
      if (exp_wd.size() == 0) begin
        check(0, "R8", "unexpected word", 64'(word_data), 64'd0);
      end else begin
        logic [WB-1:0] d;
        int f;
        d = exp_wd.pop_front();
        f = exp_wf.pop_front();
        check(word_data == d, (f == CPW) ? "R7" : "R8", "word data", 64'(word_data), 64'(d));
        check(int'(word_fill) == f, (f == CPW) ? "R7" : "R8", "word fill", 64'(word_fill), 64'(f));
      end
    end
    sym_hold = sym_valid && !sym_ready;
    prev_code = sym_code;
    word_hold = word_valid && !word_ready;
    prev_wd = word_data;
  endtask

  task automatic load(int ch, int v);
    ld_pend = 1; ld_ch = ch; ld_val = v;
    cycle();
  endtask

  task automatic do_flush();
    flush_req = 1;
    for (int i = 0; i < 200 && flush_req; i++) cycle();
  endtask

  task automatic add(int ch, int w);
    item_t it;
    it.ch = ch; it.w = w;
    drv_q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(20260106));
    for (int c = 0; c < NUM_CH; c++) mthr[c] = THR_RESET;
    macc = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!sym_valid, "R10", "sym_valid in reset", 64'(sym_valid), 0);
    check(!word_valid, "R10", "word_valid in reset", 64'(word_valid), 0);
    check(in_ready && flush_ready, "R10", "ready in reset", 64'({in_ready, flush_ready}), 3);
    rst = 0;

    // R5: directed thresholds, non-positive loads must be ignored
    load(0, 10); load(1, 1); load(2, 127); load(3, 50);
    load(3, 0); load(3, -4);
    add(3, 40); add(3, 51); add(3, -50); add(3, -51);
    add(0, 11); add(0, 10); add(0, 9); add(0, 1); add(0, 0); add(0, -1);
    add(0, -9); add(0, -10); add(0, -11); add(0, 127); add(0, -128);
    add(1, 2); add(1, 1); add(1, 0); add(1, -1); add(1, -2);
    add(2, 127); add(2, -127); add(2, -128);
    for (int i = 0; i < 60; i++) cycle();
    check(drv_q.size() == 0 && exp_sym.size() == 0, "R6", "directed symbols drained", drv_q.size(), 0);
    do_flush();
    repeat (5) cycle();
    // R8: a flush with nothing held yields no word
    do_flush();
    repeat (5) cycle();
    check(!word_valid && exp_wd.size() == 0, "R8", "empty flush emits nothing", 64'(word_valid), 0);

    // random phase
    rnd_mode = 1;
    for (int n = 0; n < 4000; n++) begin
      if (drv_q.size() < 4) begin
        int ch, w;
        ch = $urandom_range(0, NUM_CH - 1);
        if ($urandom_range(0, 1) == 0) w = $urandom_range(0, 255) - 128;
        else begin
          w = mthr[ch] + $urandom_range(0, 4) - 2;
          if ($urandom_range(0, 1) == 1) w = -w;
          if (w > 127) w = 127;
          if (w < -128) w = -128;
        end
        add(ch, w);
      end
      if ($urandom_range(0, 99) < 3) begin
        ld_pend = 1; ld_ch = $urandom_range(0, NUM_CH - 1); ld_val = $urandom_range(0, 130) - 3;
      end
      if ($urandom_range(0, 99) < 2) flush_req = 1;
      cycle();
    end
    rnd_mode = 0;
    for (int i = 0; i < 100; i++) cycle();
    do_flush();
    repeat (10) cycle();
    check(exp_sym.size() == 0 && exp_wd.size() == 0, "R9", "all codes delivered", exp_sym.size() + exp_wd.size(), 0);
    finish_run();
  end

endmodule